// File: doc/BRIEF.md
# Stepped Digital Gain Stage

This block scales a stream of signed I/Q sample pairs by a programmable gain chosen in half-decibel steps, and widens each 12-bit input lane to a 14-bit output lane. A six-bit step index selects one of 43 settings spanning −3 dB to +18 dB. The index addresses a constant table of unsigned fixed-point multipliers (4 integer bits, 12 fraction bits). Each lane then goes through a multiply, a round-half-up and a clamp to the signed 14-bit range. The two extra output bits are 12 dB of headroom, so step 6 (0 dB) maps a full-scale 12-bit input onto a full-scale 14-bit output. The reset setting is step 29 (11.5 dB).

Two sample sources reach the stage: corrected samples from an upstream I/Q correction path and raw converter samples. A configuration bit selects the raw samples so that correction can be bypassed. A host writes the step index and the bypass bit in a single register write. A new setting is picked up at a sample boundary: the gain and the source are captured together with each sample, so the I and Q lanes of a pair always share one setting.

Top module: `step_gain_stage`

## Requirements
- R1: After synchronous reset, out_valid, out_sat, out_i and out_q are 0, the active step index is 29 and bypass is off (corrected inputs selected).
- R2: Step index k selects the multiplier M(k) = round(4096 · 10^((k − 6)/40)). A lane output is floor((x · M(k) + 512) / 1024), so step 6 multiplies by exactly 4.
- R3: Rounding is half-up toward positive infinity. A product whose low 10 bits are exactly 512 rounds up for negative inputs as well as positive ones.
- R4: A result above 8191 becomes 8191 and a result below −8192 becomes −8192. out_sat is 1 with a sample when either of its lanes was clamped, and 0 otherwise.
- R5: A sample accepted at the clock edge where in_valid is high appears on out_i/out_q with out_valid high after the second following edge. Each accepted sample gives exactly one out_valid cycle.
- R6: A written step index above 42 acts as 42.
- R7: With bypass on, raw_i/raw_q are scaled. With bypass off, corr_i/corr_q are scaled.
- R8: A write with cfg_wr high takes cfg_wdata[5:0] as the step index and cfg_wdata[6] as the bypass bit.
- R9: A configuration written at edge t applies to samples accepted at edge t+2 and later. A sample accepted at edge t+1 still uses the previous setting.
- R10: In a cycle that delivers no sample, out_valid is 0 and out_i/out_q keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_wdata | input | 7 | [5:0] step index, [6] bypass |
| in_valid | input | 1 | Sample pair present on the inputs |
| corr_i | input | 12 | Corrected I sample, signed |
| corr_q | input | 12 | Corrected Q sample, signed |
| raw_i | input | 12 | Raw converter I sample, signed |
| raw_q | input | 12 | Raw converter Q sample, signed |
| out_valid | output | 1 | Output sample pair valid |
| out_i | output | 14 | Scaled I sample, signed |
| out_q | output | 14 | Scaled Q sample, signed |
| out_sat | output | 1 | Either lane was clamped for this sample |

## Verification
A host write and the acceptance of samples can fall into the same and the adjacent cycles, so the point at which a new step or source applies is the delicate case. The bench drives a write and follows it straight away with back-to-back samples. It also scatters writes at random over a continuous sample stream. A reference model delays each written setting by two edges and expects the old gain on the sample at edge t+1 and the new one from edge t+2. Clamping in one lane while the other lane stays in range is also provoked, and the shared flag is judged against both lanes.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  // Half-dB steps: 20 dB per decade of amplitude over 0.5 dB -> 40 steps/decade
  localparam int STEPS_PER_DECADE = 40;

  // Unsigned fixed-point multiplier for step k, fb fraction bits
  function automatic int gain_code(int k, int zero_idx, int fb);
    real lin;
    lin = 10.0 ** (real'(k - zero_idx) / real'(STEPS_PER_DECADE));
    return $rtoi(lin * real'(1 << fb) + 0.5);
  endfunction
endpackage

// File: rtl/dg_ctrl_reg.sv
module dg_ctrl_reg #(
  parameter int SW       = 6,
  parameter int STEP_MAX = 42,
  parameter int STEP_DEF = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_step,
  input  logic          wr_byp,
  output logic [SW-1:0] step_q,
  output logic          byp_q
);
  localparam logic [SW-1:0] MAX_C = SW'(STEP_MAX);
  localparam logic [SW-1:0] DEF_C = SW'(STEP_DEF);

  logic [SW-1:0] step_clamped;
  always_comb step_clamped = (wr_step > MAX_C) ? MAX_C : wr_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= DEF_C;
      byp_q  <= 1'b0;
    end else if (wr_en) begin
      step_q <= step_clamped;
      byp_q  <= wr_byp;
    end
  end

  a_r6_clamp: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_step > MAX_C)) |=> (step_q == MAX_C));
  a_r8_fields: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (byp_q == $past(wr_byp)));
endmodule

// File: rtl/dg_gain_rom.sv
module dg_gain_rom
  import sgs_pkg::*;
#(
  parameter int AW       = 6,
  parameter int MW       = 16,
  parameter int FB       = 12,
  parameter int DEPTH    = 43,
  parameter int ZERO_IDX = 6,
  parameter int RST_IDX  = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [MW-1:0] rd_data
);
  localparam int SLOTS = 1 << AW;
  localparam logic [MW-1:0] RST_CODE  = MW'(gain_code(RST_IDX, ZERO_IDX, FB));
  localparam logic [MW-1:0] UNITY     = MW'(1 << FB);
  localparam logic [AW-1:0] ZERO_ADDR = AW'(ZERO_IDX);

  logic [MW-1:0] rom [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_rom
    localparam int KK = (k < DEPTH) ? k : DEPTH - 1;
    assign rom[k] = MW'(gain_code(KK, ZERO_IDX, FB));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= RST_CODE;
    else     rd_data <= rom[rd_addr];
  end

  a_r2_unity_step: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ZERO_ADDR) |=> (rd_data == UNITY));
endmodule

// File: rtl/dg_scale_lane.sv
module dg_scale_lane #(
  parameter int IW = 12,
  parameter int MW = 16,
  parameter int OW = 14,
  parameter int SH = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_prod,
  input  logic signed [IW-1:0] x,
  input  logic        [MW-1:0] m,
  input  logic                 ld_out,
  output logic signed [OW-1:0] y_q,
  output logic                 sat_q
);
  localparam int PW   = IW + MW + 1;
  localparam int MAXI = (1 << (OW - 1)) - 1;
  localparam int MINI = -(1 << (OW - 1));
  localparam logic signed [PW-1:0] MAXV = PW'(MAXI);
  localparam logic signed [PW-1:0] MINV = PW'(MINI);
  localparam logic signed [PW-1:0] RND  = PW'(1 << (SH - 1));
  localparam logic signed [OW-1:0] YMAX = OW'(MAXI);
  localparam logic signed [OW-1:0] YMIN = OW'(MINI);

  logic signed [MW:0]   m_s;
  logic signed [PW-1:0] p_q;
  logic signed [PW-1:0] rnd_sum;
  logic signed [PW-1:0] r;
  logic                 hi, lo;

  assign m_s = {1'b0, m};

  always_ff @(posedge clk) begin
    if (rst)          p_q <= '0;
    else if (ld_prod) p_q <= x * m_s;
  end

  always_comb begin
    rnd_sum = p_q + RND;
    r       = rnd_sum >>> SH;
    hi      = (r > MAXV);
    lo      = (r < MINV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      sat_q <= 1'b0;
    end else if (ld_out) begin
      y_q   <= hi ? YMAX : (lo ? YMIN : r[OW-1:0]);
      sat_q <= hi | lo;
    end
  end

  a_r4_rail: assert property (@(posedge clk) disable iff (rst)
    sat_q |-> ((y_q == YMAX) || (y_q == YMIN)));
endmodule

// File: rtl/step_gain_stage.sv
module step_gain_stage #(
  parameter int IW       = 12,
  parameter int OW       = 14,
  parameter int MW       = 16,
  parameter int FB       = 12,
  parameter int SW       = 6,
  parameter int STEP_MAX = 42,
  parameter int STEP_DEF = 29,
  parameter int ZERO_IDX = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [SW:0]          cfg_wdata,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] corr_i,
  input  logic signed [IW-1:0] corr_q,
  input  logic signed [IW-1:0] raw_i,
  input  logic signed [IW-1:0] raw_q,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 out_sat
);
  localparam int LANES = 2;
  // Output shift: fraction bits minus the headroom bits gained by widening
  localparam int SH = FB - (OW - IW);

  logic [SW-1:0] step_q;
  logic          byp_q;
  logic [MW-1:0] gain_m;
  logic          byp_d;

  logic signed [IW-1:0] s1_x [LANES];
  logic [MW-1:0]        s1_m;
  logic                 s1_v, s2_v, s3_v;
  logic signed [OW-1:0] lane_y [LANES];
  logic                 lane_sat [LANES];
  logic signed [IW-1:0] sel_x [LANES];

  dg_ctrl_reg #(.SW(SW), .STEP_MAX(STEP_MAX), .STEP_DEF(STEP_DEF)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(cfg_wr),
    .wr_step(cfg_wdata[SW-1:0]), .wr_byp(cfg_wdata[SW]),
    .step_q(step_q), .byp_q(byp_q)
  );

  dg_gain_rom #(.AW(SW), .MW(MW), .FB(FB), .DEPTH(STEP_MAX + 1),
                .ZERO_IDX(ZERO_IDX), .RST_IDX(STEP_DEF)) u_rom (
    .clk(clk), .rst(rst), .rd_addr(step_q), .rd_data(gain_m)
  );

  // Bypass follows the same one-cycle path as the table read
  always_ff @(posedge clk) begin
    if (rst) byp_d <= 1'b0;
    else     byp_d <= byp_q;
  end

  always_comb begin
    sel_x[0] = byp_d ? raw_i : corr_i;
    sel_x[1] = byp_d ? raw_q : corr_q;
  end

  // Sample boundary: data, gain and source are captured together
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_m <= '0;
      for (int l = 0; l < LANES; l++) s1_x[l] <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_m <= gain_m;
        for (int l = 0; l < LANES; l++) s1_x[l] <= sel_x[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dg_scale_lane #(.IW(IW), .MW(MW), .OW(OW), .SH(SH)) u_lane (
      .clk(clk), .rst(rst), .ld_prod(s1_v), .x(s1_x[g]), .m(s1_m),
      .ld_out(s2_v), .y_q(lane_y[g]), .sat_q(lane_sat[g])
    );
  end

  assign out_valid = s3_v;
  assign out_i     = lane_y[0];
  assign out_q     = lane_y[1];
  assign out_sat   = lane_sat[0] | lane_sat[1];

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 (!out_valid && $stable(out_i) && $stable(out_q)));
  a_r7_bypass_sel: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byp_d) |=> (s1_x[0] == $past(raw_i)));
  a_r9_gain_with_sample: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (s1_m == $past(gain_m)));
endmodule

// File: tb/step_gain_stage_bench.sv
module step_gain_stage_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic signed [11:0] corr_i = '0, corr_q = '0, raw_i = '0, raw_q = '0;
  logic out_valid, out_sat;
  logic signed [13:0] out_i, out_q;

  always #(CLK_P/2) clk = ~clk;

  step_gain_stage u_step_gain_stage (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .corr_i(corr_i), .corr_q(corr_q),
    .raw_i(raw_i), .raw_q(raw_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .out_sat(out_sat)
  );

  int n_chk = 0, n_err = 0, ecount = 0;
  int m_step = 29, m_eff = 29;
  bit m_byp = 0, m_effb = 0;
  bit exp_v [4];
  int exp_i [4], exp_q [4];
  bit exp_s [4];
  string exp_t [4];
  int last_i = 0, last_q = 0;

  function automatic int gold_m(int k);
    real r;
    r = 4096.0 * $pow(10.0, (real'(k) - 6.0) / 40.0);
    return $rtoi($floor(r + 0.5));
  endfunction

  function automatic void gold_scale(int x, int k, output int y, output bit s);
    longint p;
    p = longint'(x) * longint'(gold_m(k)) + 64'sd512;
    p = p >>> 10;
    s = 1'b0;
    if (p > 8191)       begin y = 8191;  s = 1'b1; end
    else if (p < -8192) begin y = -8192; s = 1'b1; end
    else                y = int'(p);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic monitor();
    int sl;
    sl = ecount % 4;
    if (exp_v[sl]) begin
      check("R5", "out_valid", int'(out_valid), 1);
      check(exp_t[sl], "out_i", int'(out_i), exp_i[sl]);
      check(exp_t[sl], "out_q", int'(out_q), exp_q[sl]);
      check("R4", "out_sat", int'(out_sat), int'(exp_s[sl]));
      last_i = exp_i[sl];
      last_q = exp_q[sl];
      exp_v[sl] = 0;
    end else begin
      check("R10", "out_valid idle", int'(out_valid), 0);
      check("R10", "out_i hold", int'(out_i), last_i);
      check("R10", "out_q hold", int'(out_q), last_q);
    end
  endtask

  task automatic cyc(bit w, int wd, bit v, int ci, int cq, int ri, int rq, string tag);
    int yi, yq, due, st;
    bit si, sq;
    @(negedge clk);
    monitor();
    cfg_wr = w; cfg_wdata = 7'(wd); in_valid = v;
    corr_i = 12'(ci); corr_q = 12'(cq); raw_i = 12'(ri); raw_q = 12'(rq);
    @(posedge clk);
    ecount++;
    if (v) begin
      gold_scale(m_effb ? ri : ci, m_eff, yi, si);
      gold_scale(m_effb ? rq : cq, m_eff, yq, sq);
      due = (ecount + 2) % 4;
      exp_v[due] = 1; exp_i[due] = yi; exp_q[due] = yq;
      exp_s[due] = si | sq; exp_t[due] = tag;
    end
    m_eff = m_step;
    m_effb = m_byp;
    if (w) begin
      st = wd & 63;
      m_step = (st > 42) ? 42 : st;
      m_byp = ((wd >> 6) & 1) != 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic setcfg(int wd);
    cyc(1, wd, 0, 0, 0, 0, 0, "R8");
    idle(2);
  endtask

  function automatic int rnd12();
    return int'($signed(12'($urandom)));
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed;
    bit found;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "out_i", int'(out_i), 0);
    check("R1", "out_q", int'(out_q), 0);
    check("R1", "out_sat", int'(out_sat), 0);
    rst = 1'b0;

    // R1: default step 29, corrected source, first cycle after reset
    cyc(0, 0, 1, 300, -300, 2000, 2000, "R1");
    cyc(0, 0, 1, 2047, -2048, 0, 0, "R1");
    idle(3);

    // R2: unity step and extremes of the table
    setcfg(6);
    cyc(0, 0, 1, 2047, -2048, 0, 0, "R2");
    cyc(0, 0, 1, 1, -1, 0, 0, "R2");
    setcfg(0);
    cyc(0, 0, 1, -2048, 2047, 0, 0, "R2");
    cyc(0, 0, 1, 777, -5, 0, 0, "R2");
    for (int k = 0; k <= 42; k += 7) begin
      setcfg(k);
      cyc(0, 0, 1, 123, -456, 0, 0, "R2");
    end

    // R3: exact half products, negative and positive
    found = 0;
    for (int k = 0; k <= 42 && !found; k++)
      for (int x = -2048; x < 0 && !found; x++)
        if (((longint'(x) * gold_m(k)) & 1023) == 512) begin
          setcfg(k);
          cyc(0, 0, 1, x, -x, 0, 0, "R3");
          found = 1;
        end
    check("R3", "half product found", int'(found), 1);
    idle(3);

    // R4: one lane clipped, other lane in range; both rails
    setcfg(42);
    cyc(0, 0, 1, 2047, 10, 0, 0, "R4");
    cyc(0, 0, 1, 10, -2048, 0, 0, "R4");
    cyc(0, 0, 1, 5, -5, 0, 0, "R4");

    // R6: index above 42 clamps
    setcfg(63);
    cyc(0, 0, 1, 100, -100, 0, 0, "R6");
    setcfg(50);
    cyc(0, 0, 1, 2047, 60, 0, 0, "R6");

    // R7/R8: source select through bit 6
    setcfg((1 << 6) | 6);
    cyc(0, 0, 1, 5, 5, -300, 400, "R7");
    setcfg(6);
    cyc(0, 0, 1, 5, 5, -300, 400, "R7");
    setcfg((1 << 6) | 20);
    cyc(0, 0, 1, 1, 2, 1000, -1000, "R8");

    // R9: write followed at once by back-to-back samples
    setcfg(42);
    cyc(1, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 1000, -1000, 0, 0, "R9");
    cyc(0, 0, 1, 1000, -1000, 0, 0, "R9");
    cyc(1, (1 << 6) | 12, 1, 50, 60, 700, -700, "R9");
    cyc(0, 0, 1, 50, 60, 700, -700, "R9");
    cyc(0, 0, 1, 50, 60, 700, -700, "R9");
    idle(3);

    // Random traffic with scattered writes
    for (int i = 0; i < 3000; i++) begin
      bit w, v;
      w = ($urandom % 16) == 0;
      v = ($urandom % 10) < 7;
      cyc(w, int'($urandom % 128), v, rnd12(), rnd12(), rnd12(), rnd12(), "R2");
    end
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule